// File: doc/BRIEF.md
# GPIO Port Group Controller with Edge Interrupts

This block runs a set of general-purpose I/O port groups, each with up to eight pins, behind a simple synchronous register bus. For every pin there is an output latch and its output enable, an input enable that forces the read value to zero when cleared, and a function select that hands the pin to a peripheral. When a pin belongs to a peripheral, the peripheral's own data and drive enable reach the pin directly, and the GPIO data path has no effect on it.

Each pin has an interrupt flag. The flag is set on a rising or falling transition, chosen per pin, of the synchronized and gated input value. Software clears a flag by writing a one to it. Each pin also has an interrupt enable. A shared summary register holds one bit per group. A group's bit reads 1 only while at least one pin in that group has both its flag and its enable set. Each group also drives a registered interrupt request to an external interrupt controller.

The bus has one cycle of read latency. Group `g` takes word addresses `g*8` to `g*8+7`, and the summary register sits at address `NUM_GROUPS*8`.

Top module: `gpio_group_irq`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0x0000, `bus_rdata` is 0x0000, and `pin_oe`, `pin_out` and `irq` are all 0.
- R2: A read with `bus_sel`=1 and `bus_we`=0 returns its data on `bus_rdata` one clock later. `bus_rdata` holds that value until the next read. Group offset 0 is the data register: bits 15:8 are the output latch (read/write) and bits 7:0 are the input status (read-only, writes ignored). Offset 1 is the enable register: bits 15:8 are the input enables and bits 7:0 are the output enables. Each group's registers are independent.
- R3: When a pin is in GPIO mode, `pin_oe` equals its output enable and `pin_out` equals latch AND output enable, both registered one cycle after the register changes. Writing the latch while the output is disabled leaves the pin at 0.
- R4: Pin inputs pass through two synchronizing flops. An input status bit shows the synchronized pin level when its input enable is 1, and reads 0 when the enable is 0.
- R5: Offset 2, bits 7:0, selects peripheral mode per pin (1 = peripheral). In that mode `pin_oe` and `pin_out` follow `periph_oe` and `periph_out` (registered), and the input status bit reads 0. `periph_in` always carries the synchronized pin level.
- R6: Offset 3 holds the edge selects in bits 15:8 (0 = rising, 1 = falling) and the interrupt enables in bits 7:0. A flag in offset 4, bits 7:0, is set when the input status bit makes the selected transition. A transition of the opposite direction, or on a pin whose input status is held at 0, sets nothing.
- R7: Writing 1 to a flag bit at offset 4 clears it. Writing 0 leaves it unchanged.
- R8: If a selected edge and a clearing write hit the same flag in the same cycle, the flag stays set.
- R9: In the summary register, bit g is 1 exactly when group g has a pin whose flag and interrupt enable are both 1. A flag on a pin whose interrupt enable is 0 does not set the bit. Clearing the last enabled flag clears the bit.
- R10: `irq[g]` equals group g's summary condition, delayed by one clock.
- R11: Reads of an unused group offset (5 to 7), or of an address above the summary register, return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one cycle after the request |
| pin_in | input | NUM_GROUPS*NUM_PINS | Pin levels, asynchronous |
| pin_out | output | NUM_GROUPS*NUM_PINS | Pin drive value |
| pin_oe | output | NUM_GROUPS*NUM_PINS | Pin drive enable |
| periph_out | input | NUM_GROUPS*NUM_PINS | Peripheral drive value |
| periph_oe | input | NUM_GROUPS*NUM_PINS | Peripheral drive enable |
| periph_in | output | NUM_GROUPS*NUM_PINS | Synchronized pin level for peripherals |
| irq | output | NUM_GROUPS | Per-group interrupt request |

## Verification
The assertions assume that the bus inputs are free of X after reset and that a read is a single-cycle `bus_sel` pulse. They also assume that any pin change reaches the edge detector only after the two synchronizer stages. The bench changes pin levels only on falling clock edges and waits at least five cycles before it reads the results. The one exception is the collision case: there the pin change is timed so that the detected edge lands in the same cycle as the clearing write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_W   = 16;
  localparam int FIELD_W = 8;
  localparam int OFS_W   = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_DATA   = 3'd0,
    OFS_ENABLE = 3'd1,
    OFS_FUNC   = 3'd2,
    OFS_IRQCTL = 3'd3,
    OFS_FLAGS  = 3'd4
  } reg_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] edge_sel,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] flags,
  output logic [WIDTH-1:0] hit
);
  logic [WIDTH-1:0] prev;
  logic [WIDTH-1:0] rise;
  logic [WIDTH-1:0] fall;

  assign rise = level & ~prev;
  assign fall = ~level & prev;
  assign hit  = (rise & ~edge_sel) | (fall & edge_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '0;
      flags <= '0;
    end else begin
      prev  <= level;
      flags <= (flags & ~clr_mask) | hit;
    end
  end

  // R6 / R8: a detected edge always leaves its flag set, even against a clear
  p_edge_sets_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & $past(hit)) == $past(hit)));

  // R7: a clear with no competing edge empties the flag
  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (rst)
    ((clr_mask & ~hit) != '0) |=> ((flags & $past(clr_mask & ~hit)) == '0));
endmodule

// File: rtl/gpio_port_group.sv
module gpio_port_group
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [OFS_W-1:0]    ofs,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] periph_out,
  input  logic [NUM_PINS-1:0] periph_oe,
  output logic [NUM_PINS-1:0] periph_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                pend,
  output logic                irq
);
  logic [NUM_PINS-1:0] out_latch, in_en, out_en, func_sel, edge_sel, irq_en;
  logic [NUM_PINS-1:0] pin_sync, in_stat, clr_mask, flags, hit;

  function automatic logic [FIELD_W-1:0] widen(input logic [NUM_PINS-1:0] v);
    return FIELD_W'(v);
  endfunction

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  assign in_stat   = pin_sync & in_en & ~func_sel;
  assign periph_in = pin_sync;
  assign clr_mask  = (wr_en && ofs == OFS_FLAGS) ? wdata[NUM_PINS-1:0] : '0;

  gpio_edge_flags #(.WIDTH(NUM_PINS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .level    (in_stat),
    .edge_sel (edge_sel),
    .clr_mask (clr_mask),
    .flags    (flags),
    .hit      (hit)
  );

  assign pend = |(flags & irq_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_latch <= '0;
      in_en     <= '0;
      out_en    <= '0;
      func_sel  <= '0;
      edge_sel  <= '0;
      irq_en    <= '0;
    end else if (wr_en) begin
      case (ofs)
        OFS_DATA:   out_latch <= wdata[FIELD_W +: NUM_PINS];
        OFS_ENABLE: begin
          in_en  <= wdata[FIELD_W +: NUM_PINS];
          out_en <= wdata[0 +: NUM_PINS];
        end
        OFS_FUNC:   func_sel <= wdata[0 +: NUM_PINS];
        OFS_IRQCTL: begin
          edge_sel <= wdata[FIELD_W +: NUM_PINS];
          irq_en   <= wdata[0 +: NUM_PINS];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
      irq     <= 1'b0;
    end else begin
      pin_out <= (func_sel & periph_out) | (~func_sel & out_en & out_latch);
      pin_oe  <= (func_sel & periph_oe) | (~func_sel & out_en);
      irq     <= pend;
    end
  end

  always_comb begin
    case (ofs)
      OFS_DATA:   rd_data = {widen(out_latch), widen(in_stat)};
      OFS_ENABLE: rd_data = {widen(in_en), widen(out_en)};
      OFS_FUNC:   rd_data = {{FIELD_W{1'b0}}, widen(func_sel)};
      OFS_IRQCTL: rd_data = {widen(edge_sel), widen(irq_en)};
      OFS_FLAGS:  rd_data = {{FIELD_W{1'b0}}, widen(flags)};
      default:    rd_data = '0;
    endcase
  end

  // R3: a GPIO pin whose output enable is off never drives
  p_gpio_oe_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_oe & ~$past(func_sel) & ~$past(out_en)) == '0));

  // R5: a peripheral-owned pin mirrors the peripheral drive
  p_periph_drive_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_out & $past(func_sel)) == ($past(periph_out) & $past(func_sel))));
endmodule

// File: rtl/gpio_group_irq.sv
module gpio_group_irq
  import gpio_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int NUM_PINS   = 8,
  parameter int ADDR_W     = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bus_sel,
  input  logic                             bus_we,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [REG_W-1:0]                 bus_wdata,
  output logic [REG_W-1:0]                 bus_rdata,
  input  logic [NUM_GROUPS*NUM_PINS-1:0]   pin_in,
  output logic [NUM_GROUPS*NUM_PINS-1:0]   pin_out,
  output logic [NUM_GROUPS*NUM_PINS-1:0]   pin_oe,
  input  logic [NUM_GROUPS*NUM_PINS-1:0]   periph_out,
  input  logic [NUM_GROUPS*NUM_PINS-1:0]   periph_oe,
  output logic [NUM_GROUPS*NUM_PINS-1:0]   periph_in,
  output logic [NUM_GROUPS-1:0]            irq
);
  localparam int GRP_W    = ADDR_W - OFS_W;
  localparam int SUM_ADDR = NUM_GROUPS << OFS_W;

  logic [GRP_W-1:0]      grp_idx;
  logic [OFS_W-1:0]      ofs;
  logic [REG_W-1:0]      grp_rd [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] pend;
  logic [REG_W-1:0]      rd_mux;

  assign grp_idx = bus_addr[ADDR_W-1:OFS_W];
  assign ofs     = bus_addr[OFS_W-1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic wr_g;
    assign wr_g = bus_sel && bus_we && (grp_idx == GRP_W'(g));

    gpio_port_group #(.NUM_PINS(NUM_PINS)) u_group (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_g),
      .ofs        (ofs),
      .wdata      (bus_wdata),
      .rd_data    (grp_rd[g]),
      .pin_in     (pin_in[g*NUM_PINS +: NUM_PINS]),
      .periph_out (periph_out[g*NUM_PINS +: NUM_PINS]),
      .periph_oe  (periph_oe[g*NUM_PINS +: NUM_PINS]),
      .periph_in  (periph_in[g*NUM_PINS +: NUM_PINS]),
      .pin_out    (pin_out[g*NUM_PINS +: NUM_PINS]),
      .pin_oe     (pin_oe[g*NUM_PINS +: NUM_PINS]),
      .pend       (pend[g]),
      .irq        (irq[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(SUM_ADDR)) begin
      rd_mux = REG_W'(pend);
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (grp_idx == GRP_W'(g)) rd_mux = grp_rd[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= '0;
    else if (bus_sel && !bus_we) bus_rdata <= rd_mux;
  end

  // R10: each request line trails its group's pending condition by one clock
  p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(pend)));

  // R9: a summary read returns the pending condition of every group
  p_summary_read_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == ADDR_W'(SUM_ADDR))
      |=> (bus_rdata == REG_W'($past(pend))));

  // R2: read data holds while no read is issued
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_group_irq_bench.sv
module gpio_group_irq_bench;
  localparam int NG = 2;
  localparam int NP = 8;
  localparam int AW = 5;
  localparam int NV = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_sel = 1'b0;
  logic              bus_we = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [15:0]       bus_wdata = '0;
  logic [15:0]       bus_rdata;
  logic [NG*NP-1:0]  pin_in = '0;
  logic [NG*NP-1:0]  pin_out, pin_oe, periph_in;
  logic [NG*NP-1:0]  periph_out = '0;
  logic [NG*NP-1:0]  periph_oe = '0;
  logic [NG-1:0]     irq;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  gpio_group_irq #(.NUM_GROUPS(NG), .NUM_PINS(NP), .ADDR_W(AW)) u_gpio_group_irq (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .periph_out(periph_out), .periph_oe(periph_oe),
    .periph_in(periph_in), .irq(irq)
  );

  // {we, addr[4:0], wdata[15:0], expected[15:0]}
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 5'd0,  16'h0000, 16'h0000},
    {1'b1, 5'd0,  16'hA5FF, 16'h0000},
    {1'b0, 5'd0,  16'h0000, 16'hA500},
    {1'b1, 5'd1,  16'h0F3C, 16'h0000},
    {1'b0, 5'd1,  16'h0000, 16'h0F3C},
    {1'b1, 5'd3,  16'h80F0, 16'h0000},
    {1'b0, 5'd3,  16'h0000, 16'h80F0},
    {1'b1, 5'd2,  16'h0081, 16'h0000},
    {1'b0, 5'd2,  16'h0000, 16'h0081},
    {1'b1, 5'd4,  16'h00FF, 16'h0000},
    {1'b0, 5'd4,  16'h0000, 16'h0000},
    {1'b0, 5'd5,  16'h0000, 16'h0000},
    {1'b0, 5'd17, 16'h0000, 16'h0000},
    {1'b0, 5'd8,  16'h0000, 16'h0000},
    {1'b0, 5'd16, 16'h0000, 16'h0000}
  };
  localparam string VREQ [NV] = '{
    "R1", "", "R2", "", "R2", "", "R6", "", "R5", "", "R7", "R11", "R11", "R2", "R9"
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    @(negedge clk);
    do_reset();

    // Register table walk (group 0, all pins low)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37]) begin
        bus_write(VEC[i][36:32], VEC[i][31:16]);
      end else begin
        bus_read(VEC[i][36:32], rd);
        check(VREQ[i], $sformatf("table entry %0d", i), 32'(rd), 32'(VEC[i][15:0]));
      end
    end

    // R1: reset returns everything to zero
    do_reset();
    check("R1", "rdata after reset", 32'(bus_rdata), 32'h0);
    check("R1", "pin_oe after reset", 32'(pin_oe), 32'h0);
    check("R1", "pin_out after reset", 32'(pin_out), 32'h0);
    check("R1", "irq after reset", 32'(irq), 32'h0);
    bus_read(5'd1, rd);
    check("R1", "enable reg after reset", 32'(rd), 32'h0);

    // R3: output gating
    bus_write(5'd1, 16'h000F);
    bus_write(5'd0, 16'hA500);
    idle(2);
    check("R3", "pin_oe gpio", 32'(pin_oe[7:0]), 32'h0F);
    check("R3", "pin_out gpio", 32'(pin_out[7:0]), 32'h05);
    bus_write(5'd0, 16'h5A00);
    idle(2);
    check("R3", "latch write with output off", 32'(pin_out[7:0]), 32'h0A);

    // R4 / R6: input enables and rising edges
    bus_write(5'd1, 16'h0F0F);
    pin_in[7:0] = 8'hFF;
    idle(5);
    bus_read(5'd0, rd);
    check("R4", "input status gated", 32'(rd), 32'h5A0F);
    bus_read(5'd4, rd);
    check("R6", "rising flags on enabled inputs", 32'(rd), 32'h000F);
    bus_read(5'd16, rd);
    check("R9", "summary with interrupts disabled", 32'(rd), 32'h0000);
    check("R10", "irq with interrupts disabled", 32'(irq), 32'h0);

    // R9 / R10: enable one pin's interrupt
    bus_write(5'd3, 16'h0001);
    bus_read(5'd16, rd);
    check("R9", "summary set by enabled flag", 32'(rd), 32'h0001);
    idle(1);
    check("R10", "irq raised", 32'(irq), 32'h1);

    // R7: write-one-to-clear
    bus_write(5'd4, 16'h0002);
    bus_read(5'd4, rd);
    check("R7", "clear one flag", 32'(rd), 32'h000D);
    bus_write(5'd4, 16'h0000);
    bus_read(5'd4, rd);
    check("R7", "zero write keeps flags", 32'(rd), 32'h000D);
    bus_read(5'd16, rd);
    check("R9", "summary kept by enabled flag", 32'(rd), 32'h0001);
    bus_write(5'd4, 16'h0001);
    bus_read(5'd16, rd);
    check("R9", "summary cleared with last enabled flag", 32'(rd), 32'h0000);
    idle(1);
    check("R10", "irq dropped", 32'(irq), 32'h0);

    // R6: falling edges
    bus_write(5'd3, 16'h0F00);
    pin_in[7:0] = 8'hF0;
    idle(5);
    bus_read(5'd4, rd);
    check("R6", "falling flags", 32'(rd), 32'h000F);
    bus_write(5'd4, 16'h00FF);
    bus_read(5'd4, rd);
    check("R7", "clear all flags", 32'(rd), 32'h0000);

    // R8: edge and clear in the same cycle
    bus_write(5'd3, 16'h0000);
    pin_in[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_write(5'd4, 16'h0001);
    bus_read(5'd4, rd);
    check("R8", "set wins over clear", 32'(rd), 32'h0001);
    bus_write(5'd4, 16'h0001);
    bus_read(5'd4, rd);
    check("R7", "plain clear after collision", 32'(rd), 32'h0000);

    // R5: peripheral mode on pins 0 and 7
    bus_write(5'd2, 16'h0081);
    periph_oe  = '1;
    periph_out[7:0] = 8'h80;
    pin_in[7:0] = 8'hFF;
    idle(5);
    check("R5", "pin_oe mixed mode", 32'(pin_oe[7:0]), 32'h8F);
    check("R5", "pin_out mixed mode", 32'(pin_out[7:0]), 32'h8A);
    check("R5", "periph_in level", 32'(periph_in[7:0]), 32'hFF);
    bus_read(5'd0, rd);
    check("R5", "input status hides peripheral pins", 32'(rd), 32'h5A0E);

    // R9 / R10: second group independent summary bit
    bus_write(5'd9, 16'h0100);
    bus_write(5'd11, 16'h0001);
    pin_in[8] = 1'b1;
    idle(5);
    bus_read(5'd16, rd);
    check("R9", "summary for group 1", 32'(rd), 32'h0002);
    check("R10", "irq per group", 32'(irq), 32'h2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule